// File: doc/BRIEF.md
# Fetch-to-Execute Flushable Queue

This block is a short queue that sits between an instruction fetch stage and an execute stage. Each slot holds one fetched instruction word, the address it was fetched from, and the address that fetch guessed would come next. The fetch side pushes slots. The execute side pops the oldest slot once it has used it. When execute finds that a guess was wrong, it flushes the whole queue instead.

Push, pop and flush are all taken in the same clock cycle without conflict. A build-time parameter, `ORDER`, decides what happens to a push that arrives in the same cycle as a flush:

- `ENQ_THEN_CLEAR`: the push is treated as wrong-path work and is flushed with everything else.
- `CLEAR_THEN_ENQ`: the flush takes effect first, so the pushed slot becomes the only survivor.

A push into a full queue and a pop from an empty queue are both dropped. Either one sets an error flag that stays set until reset.

Top module: `fe_flush_queue`

## Requirements
- R1: While `rst_n` is low the queue is empty (`empty`=1, `full`=0) and `err`=0, and it stays so on the first cycle after release.
- R2: Slots leave in the order they were pushed, and `head_instr`, `head_pc` and `head_ppc` always show the three fields of the oldest slot unchanged.
- R3: A push while `full`=1 and `clr`=0 is dropped: the stored slots and the head are unchanged, and `err` becomes 1 on the next cycle.
- R4: A pop while `empty`=1 and `clr`=0 is dropped and sets `err` on the next cycle.
- R5: When the queue is neither full nor empty, a push and a pop in the same cycle are both taken and the occupancy is unchanged. When the queue is full, a same-cycle pop is taken and the push is dropped (R3).
- R6: A flush with no push leaves the queue empty on the next cycle, in both orderings.
- R7: With `ORDER`=`ENQ_THEN_CLEAR`, a flush and a push in the same cycle leave the queue empty on the next cycle, and `err` does not change.
- R8: With `ORDER`=`CLEAR_THEN_ENQ`, a flush and a push in the same cycle leave exactly the pushed slot at the head, even when the queue was full, and `err` does not change.
- R9: `err` is sticky: once set, it stays at 1 until reset.
- R10: `full` is 1 exactly when `DEPTH` slots are held, and `empty` is 1 exactly when none are held. The two are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| enq | input | 1 | Push request from fetch |
| enq_instr | input | INSTR_W | Instruction word to push |
| enq_pc | input | ADDR_W | Fetch address of that instruction |
| enq_ppc | input | ADDR_W | Guessed next fetch address |
| deq | input | 1 | Pop request from execute |
| clr | input | 1 | Flush request from execute |
| full | output | 1 | All slots occupied |
| empty | output | 1 | No slot occupied |
| head_instr | output | INSTR_W | Instruction word of the oldest slot |
| head_pc | output | ADDR_W | Fetch address of the oldest slot |
| head_ppc | output | ADDR_W | Guessed next address of the oldest slot |
| err | output | 1 | Sticky flag for a dropped push or pop |

## Verification
The properties assume that the execute side never raises `deq` and `clr` in the same cycle. If it did, the design lets the flush win and ignores the pop, but no property describes that case. The stimulus keeps within this assumption: every table row and every randomly drawn cycle that asks for a flush forces the pop request low. Pushes that hit a full queue and pops that hit an empty one are generated on purpose, so the drop and error paths are exercised under both orderings.

// File: rtl/fq_pkg.sv
`timescale 1ns/1ps
package fq_pkg;

    // Ordering of a same-cycle flush against a same-cycle push
    typedef enum logic {
        ENQ_THEN_CLEAR = 1'b0,  // push is flushed together with the queue
        CLEAR_THEN_ENQ = 1'b1   // queue is flushed, then the push lands
    } fq_order_e;

endpackage

// File: rtl/fq_ctrl.sv
`timescale 1ns/1ps
module fq_ctrl
    import fq_pkg::*;
#(
    parameter int        DEPTH = 2,
    parameter fq_order_e ORDER = ENQ_THEN_CLEAR,
    localparam int       PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int       CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enq,
    input  logic          deq,
    input  logic          clr,
    output logic          wr_en,
    output logic [PW-1:0] wr_idx,
    output logic [PW-1:0] rd_idx,
    output logic          full,
    output logic          empty,
    output logic          err
);

    localparam logic KEEP_ENQ = (ORDER == CLEAR_THEN_ENQ);

    typedef struct packed {
        logic [PW-1:0] rd;
        logic [PW-1:0] wr;
        logic [CW-1:0] cnt;
        logic          err;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  full_q, empty_q, acc_enq, acc_deq;

    // Advance a slot pointer, wrapping at DEPTH (non power of two allowed)
    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        if (p == PW'(DEPTH - 1)) begin
            return '0;
        end
        return p + PW'(1);
    endfunction

    always_comb begin
        st_d    = st_q;
        full_q  = (st_q.cnt == CW'(DEPTH));
        empty_q = (st_q.cnt == '0);
        // a flush either discards the push or makes room for it
        acc_enq = enq && (clr ? KEEP_ENQ : !full_q);
        acc_deq = deq && !clr && !empty_q;

        if (clr) begin
            st_d.rd  = '0;
            st_d.wr  = acc_enq ? bump('0) : '0;
            st_d.cnt = acc_enq ? CW'(1) : '0;
        end else begin
            if (acc_enq) begin
                st_d.wr = bump(st_q.wr);
            end
            if (acc_deq) begin
                st_d.rd = bump(st_q.rd);
            end
            st_d.cnt = st_q.cnt + CW'(acc_enq) - CW'(acc_deq);
        end

        st_d.err = st_q.err
                 | (enq && full_q  && !clr)
                 | (deq && empty_q && !clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en  = acc_enq;
    assign wr_idx = clr ? '0 : st_q.wr;
    assign rd_idx = st_q.rd;
    assign full   = full_q;
    assign empty  = empty_q;
    assign err    = st_q.err;

endmodule

// File: rtl/fq_store.sv
`timescale 1ns/1ps
module fq_store #(
    parameter int  DEPTH = 2,
    parameter int  EW    = 96,
    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_idx,
    input  logic [EW-1:0] wr_data,
    input  logic [PW-1:0] rd_idx,
    output logic [EW-1:0] rd_data
);

    logic [EW-1:0] slot_d [DEPTH];
    logic [EW-1:0] slot_q [DEPTH];

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        always_comb begin
            slot_d[s] = slot_q[s];
            if (wr_en && (wr_idx == PW'(s))) begin
                slot_d[s] = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[s] <= '0;
            end else begin
                slot_q[s] <= slot_d[s];
            end
        end
    end

    assign rd_data = slot_q[rd_idx];

endmodule

// File: rtl/fe_flush_queue.sv
`timescale 1ns/1ps
module fe_flush_queue
    import fq_pkg::*;
#(
    parameter int        DEPTH   = 2,
    parameter int        INSTR_W = 32,
    parameter int        ADDR_W  = 32,
    parameter fq_order_e ORDER   = ENQ_THEN_CLEAR
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enq,
    input  logic [INSTR_W-1:0] enq_instr,
    input  logic [ADDR_W-1:0]  enq_pc,
    input  logic [ADDR_W-1:0]  enq_ppc,
    input  logic               deq,
    input  logic               clr,
    output logic               full,
    output logic               empty,
    output logic [INSTR_W-1:0] head_instr,
    output logic [ADDR_W-1:0]  head_pc,
    output logic [ADDR_W-1:0]  head_ppc,
    output logic               err
);

    localparam int EW = INSTR_W + 2 * ADDR_W;
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic          wr_en;
    logic [PW-1:0] wr_idx, rd_idx;
    logic [EW-1:0] wr_data, rd_data;

    assign wr_data = {enq_instr, enq_pc, enq_ppc};

    fq_ctrl #(
        .DEPTH (DEPTH),
        .ORDER (ORDER)
    ) ctrl_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .enq    (enq),
        .deq    (deq),
        .clr    (clr),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .rd_idx (rd_idx),
        .full   (full),
        .empty  (empty),
        .err    (err)
    );

    fq_store #(
        .DEPTH (DEPTH),
        .EW    (EW)
    ) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    assign {head_instr, head_pc, head_ppc} = rd_data;

endmodule

// File: rtl/fq_checker.sv
`timescale 1ns/1ps
module fq_checker
    import fq_pkg::*;
#(
    parameter fq_order_e ORDER  = ENQ_THEN_CLEAR,
    parameter int        ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enq,
    input logic              deq,
    input logic              clr,
    input logic [ADDR_W-1:0] enq_pc,
    input logic              full,
    input logic              empty,
    input logic [ADDR_W-1:0] head_pc,
    input logic              err
);

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (empty && !full && !err));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (enq && full && !clr && !deq) |=> (full && err && $stable(head_pc)));

    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (deq && empty && !clr && !enq) |=> (empty && err));

    assert_pass_through_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (enq && deq && !clr && !full && !empty)
        |=> (full == $past(full) && empty == $past(empty)));

    assert_flush_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !enq) |=> empty);

    if (ORDER == ENQ_THEN_CLEAR) begin : g_enq_first
        assert_flush_drops_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (clr && enq) |=> (empty && err == $past(err)));
    end else begin : g_clr_first
        assert_flush_keeps_push_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (clr && enq) |=> (!empty && head_pc == $past(enq_pc) && err == $past(err)));
    end

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

endmodule

bind fe_flush_queue fq_checker #(
    .ORDER  (ORDER),
    .ADDR_W (ADDR_W)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .enq     (enq),
    .deq     (deq),
    .clr     (clr),
    .enq_pc  (enq_pc),
    .full    (full),
    .empty   (empty),
    .head_pc (head_pc),
    .err     (err)
);

// File: tb/fe_flush_queue_tb_top.sv
`timescale 1ns/1ps
module fe_flush_queue_tb_top;
    import fq_pkg::*;

    localparam int DEPTH = 2;
    localparam int NROW  = 24;
    // rows are {enq, deq, clr}; deq and clr are never both set
    localparam logic [2:0] STIM [NROW] = '{
        3'b100, 3'b100, 3'b100, 3'b010, 3'b110, 3'b010, 3'b010, 3'b010,
        3'b100, 3'b001, 3'b100, 3'b100, 3'b101, 3'b010, 3'b100, 3'b110,
        3'b101, 3'b000, 3'b100, 3'b100, 3'b110, 3'b010, 3'b001, 3'b010
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enq = 1'b0, deq = 1'b0, clr = 1'b0;
    logic [31:0] enq_instr = '0, enq_pc = '0, enq_ppc = '0;
    logic        full_w  [2];
    logic        empty_w [2];
    logic        err_w   [2];
    logic [31:0] hi_w [2], hp_w [2], hn_w [2];

    logic [95:0] mq [2][$];
    logic        merr [2];
    int          total = 0, bad = 0, seq = 0;
    bit          done = 0;

    always #5 clk = ~clk;

    fe_flush_queue #(.DEPTH(DEPTH), .ORDER(ENQ_THEN_CLEAR)) dut_i (
        .clk(clk), .rst_n(rst_n), .enq(enq), .enq_instr(enq_instr),
        .enq_pc(enq_pc), .enq_ppc(enq_ppc), .deq(deq), .clr(clr),
        .full(full_w[0]), .empty(empty_w[0]), .head_instr(hi_w[0]),
        .head_pc(hp_w[0]), .head_ppc(hn_w[0]), .err(err_w[0]));

    fe_flush_queue #(.DEPTH(DEPTH), .ORDER(CLEAR_THEN_ENQ)) dut_k (
        .clk(clk), .rst_n(rst_n), .enq(enq), .enq_instr(enq_instr),
        .enq_pc(enq_pc), .enq_ppc(enq_ppc), .deq(deq), .clr(clr),
        .full(full_w[1]), .empty(empty_w[1]), .head_instr(hi_w[1]),
        .head_pc(hp_w[1]), .head_ppc(hn_w[1]), .err(err_w[1]));

    task automatic chk(string tag, string what, logic [95:0] act, logic [95:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // compare both DUTs against the reference queues
    task automatic compare(string tag);
        for (int m = 0; m < 2; m++) begin
            chk(tag, (m == 0) ? "empty/m0" : "empty/m1", 96'(empty_w[m]), 96'(mq[m].size() == 0));
            chk(tag, (m == 0) ? "full/m0"  : "full/m1",  96'(full_w[m]),  96'(mq[m].size() == DEPTH));
            chk(tag, (m == 0) ? "err/m0"   : "err/m1",   96'(err_w[m]),   96'(merr[m]));
            if (mq[m].size() != 0) begin
                chk(tag, (m == 0) ? "head/m0" : "head/m1",
                    {hi_w[m], hp_w[m], hn_w[m]}, mq[m][0]);
            end
        end
    endtask

    // one cycle: drive at negedge, update models, compare at next negedge
    task automatic step(logic e, logic d, logic c, string tag);
        logic [95:0] dat;
        seq++;
        dat = {32'hC0DE_0000 ^ 32'(seq), 32'(seq) << 2, (32'(seq) << 2) + 32'd4};
        {enq_instr, enq_pc, enq_ppc} = dat;
        enq = e; deq = d; clr = c;
        for (int m = 0; m < 2; m++) begin
            bit fl, em;
            fl = (mq[m].size() == DEPTH);
            em = (mq[m].size() == 0);
            if (c) begin
                mq[m].delete();
                if (e && m == 1) mq[m].push_back(dat);
            end else begin
                if (e && fl) merr[m] = 1'b1;
                if (d && em) merr[m] = 1'b1;
                if (d && !em) void'(mq[m].pop_front());
                if (e && !fl) mq[m].push_back(dat);
            end
        end
        @(posedge clk);
        @(negedge clk);
        enq = 1'b0; deq = 1'b0; clr = 1'b0;
        compare(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        for (int m = 0; m < 2; m++) begin
            mq[m].delete();
            merr[m] = 1'b0;
        end
        @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1");
    endtask

    initial begin
        for (int m = 0; m < 2; m++) merr[m] = 1'b0;
        repeat (2) @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1");

        // table walk
        for (int i = 0; i < NROW; i++) begin
            step(STIM[i][2], STIM[i][1], STIM[i][0], "R2");
        end

        // R3: push into a full queue is dropped, head kept
        do_reset();
        step(1, 0, 0, "R2");
        step(1, 0, 0, "R10");
        chk("R10", "full after DEPTH pushes", 96'(full_w[0]), 96'(1));
        step(1, 0, 0, "R3");
        chk("R3", "err after overflow", 96'(err_w[0]), 96'(1));
        chk("R3", "head pc kept", 96'(hp_w[0]), 96'(32'(seq - 2) << 2));
        step(0, 1, 0, "R9");
        chk("R9", "err stays set", 96'(err_w[1]), 96'(1));

        // R4: pop from empty is dropped
        do_reset();
        step(0, 1, 0, "R4");
        chk("R4", "err after underflow", 96'(err_w[0]), 96'(1));
        chk("R4", "still empty", 96'(empty_w[0]), 96'(1));

        // R5: push+pop with one slot held keeps occupancy
        do_reset();
        step(1, 0, 0, "R5");
        step(1, 1, 0, "R5");
        chk("R5", "not empty", 96'(empty_w[0]), 96'(0));
        chk("R5", "not full", 96'(full_w[0]), 96'(0));
        chk("R5", "head is newer", 96'(hp_w[0]), 96'(32'(seq) << 2));
        // R5: full with push+pop: pop taken, push dropped
        step(1, 0, 0, "R5");
        step(1, 1, 0, "R5");
        chk("R5", "one slot left", 96'(full_w[0]), 96'(0));

        // R6: flush alone
        step(0, 0, 1, "R6");
        chk("R6", "empty after flush", 96'(empty_w[1]), 96'(1));

        // R7 / R8: flush with push on a full queue
        do_reset();
        step(1, 0, 0, "R2");
        step(1, 0, 0, "R2");
        step(1, 0, 1, "R7");
        chk("R7", "push flushed", 96'(empty_w[0]), 96'(1));
        chk("R8", "push survives", 96'(empty_w[1]), 96'(0));
        chk("R8", "survivor pc", 96'(hp_w[1]), 96'(32'(seq) << 2));
        chk("R8", "err unchanged", 96'(err_w[1]), 96'(0));
        step(0, 1, 0, "R8");
        chk("R8", "single slot", 96'(empty_w[1]), 96'(1));

        // random mix, flush never together with pop
        do_reset();
        for (int i = 0; i < 400; i++) begin
            logic e, d, c;
            e = 1'($urandom_range(0, 1));
            c = ($urandom_range(0, 7) == 0);
            d = c ? 1'b0 : 1'($urandom_range(0, 1));
            step(e, d, c, "R2");
        end
        do_reset();

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule